// File: doc/BRIEF.md
# Single-Car Elevator Sequencer with Run-Time Floor Count

This block sequences one elevator car. For each floor it has two conditions: the door standing open at that floor, or the car travelling toward that floor. It latches three kinds of calls: destination buttons inside the car, up-calls in the hall, and down-calls in the hall. When the door is open it chooses the next stop. When the position sensor of the chosen floor goes from low to high, the car arrives and the door opens there.

The number of active floors is set at run time by a floor-select code, up to a synthesis-time maximum. The same netlist therefore serves a taller building once the code is changed. Calls and sensors for floors above the active count are ignored. The car serves in sweeps: while the sweep goes upward it stops at in-car and up-call floors above it in order, and it turns to a down-call above only when no upward stop remains. The downward sweep works the same way, mirrored.

Top module: `elev_car_fsm`

## Requirements
- R1: After a synchronous active-low reset, the car is open at the lowest floor (index 0), the service direction is up, no call is pending and the floor-select code reads as 0.
- R2: A floor-select code v gives max(2, min(MAX_FLOORS, v-1)) active floors. Code 5'b01010 gives nine floors (indices 0 to 8), and any code of 3 or more whose v-1 exceeds the maximum is clamped to MAX_FLOORS.
- R3: The following are ignored and leave the outputs unchanged: a button, hall call or sensor at a floor index at or above the active count, an up-call at the top active floor, and a down-call at floor 0.
- R4: A one-cycle press is held until served. With the door open, a press sampled at clock edge k makes the car depart at edge k+1.
- R5: state_o[FLW] is 1 while travelling and 0 while open. Its low FLW bits carry the target floor while travelling and the current floor while open. door_open_o is high exactly when the car is open.
- R6: While travelling, a 0-to-1 change of the target floor's sensor between two edges moves the car to open at the target on the second of those edges.
- R7: A target sensor that stays high, and any sensor pulse at a floor other than the target, cause no arrival.
- R8: When the door is open and the direction is up, the next stop is the nearest floor above the car with an in-car or up-call. If there is none, the next stop is the highest down-call above the car and the direction becomes down.
- R9: With the direction down, the mirror rule applies: the next stop is the nearest floor below with an in-car or down-call, otherwise the lowest up-call below (direction becomes up). When nothing lies ahead, the rule for the other sweep is tried.
- R10: While the door is open at floor p, the in-car call at p and the hall call at p for the current direction are discarded. If only the opposite hall call at p is pending, the direction flips and the car stays open.
- R11: The service direction dir_up_o does not change while the car is travelling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| floor_code_i | input | CFG_W | Floor-select code, registered once per cycle |
| car_btn_i | input | MAX_FLOORS | In-car destination buttons, one per floor |
| hall_up_i | input | MAX_FLOORS | Up-call hall buttons, one per floor |
| hall_dn_i | input | MAX_FLOORS | Down-call hall buttons, one per floor |
| sensor_i | input | MAX_FLOORS | Position sensors, high while the car is level with that floor |
| state_o | output | FLW+1 | {travelling, floor index} |
| door_open_o | output | 1 | Door open |
| dir_up_o | output | 1 | Service direction, 1 = up |

## Verification
The hardest situation to reach is a call that is deferred: a down-call above the car must wait while in-car and up-calls above it are still pending, and an up-call below must wait while the downward sweep finishes. Directed sequences raise several calls in the same cycle from a parked car and step the sensors one stop at a time, so the order of stops is visible on state_o. A long random phase then pulses the sensor of the model's current target, adds stray sensor noise, and switches the floor count while the car is parked. Held sensors and out-of-range calls have their own directed cases.

// File: rtl/elev_pkg.sv
// Shared types and helpers for the elevator car sequencer.
// Assumes: floor indices are zero-based; the active floor count is never below 2.
package elev_pkg;

    typedef enum logic {
        CAR_OPEN   = 1'b0,
        CAR_MOVING = 1'b1
    } car_mode_e;

    // Map a floor-select code onto an active floor count, clamped to [2, maxf].
    function automatic int active_floors(input int code, input int maxf);
        int n;
        if (code < 3)             n = 2;
        else if (code - 1 > maxf) n = maxf;
        else                      n = code - 1;
        return n;
    endfunction

endpackage

// File: rtl/elev_cfg_decode.sv
// Registers the floor-select code and expands it into per-floor validity masks
// for car buttons, up-calls and down-calls.
// Assumes: the code changes only while the car is parked with the door open.
module elev_cfg_decode #(
    parameter int N     = 15,
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] code_i,
    output logic [N-1:0]     floor_mask_o,
    output logic [N-1:0]     up_mask_o,
    output logic [N-1:0]     dn_mask_o
);
    import elev_pkg::*;

    logic [CFG_W-1:0] code_q;
    int               nfl;

    // Capture the code each cycle; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_i;
    end

    // Decode the captured code into a floor count.
    always_comb nfl = active_floors(int'(code_q), N);

    for (genvar k = 0; k < N; k++) begin : g_mask
        assign floor_mask_o[k] = (k < nfl);
        assign up_mask_o[k]    = (k < nfl - 1);
        assign dn_mask_o[k]    = (k >= 1) && (k < nfl);
    end

    // The two lowest floors are always in service.
    assert_min_floors_R2: assert property (@(posedge clk) disable iff (!rst_n)
        floor_mask_o[1:0] == 2'b11 && !dn_mask_o[0]);

endmodule

// File: rtl/elev_req_latch.sv
// One bank of sticky call bits: each bit is set by a press, dropped when its
// floor leaves the active range, and cleared when served.
// Assumes: set, mask and clear are all synchronous to clk.
module elev_req_latch #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] req_o
);
    logic [N-1:0] req_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        // Hold, set or drop the call for floor k.
        always_ff @(posedge clk) begin
            if (!rst_n) req_q[k] <= 1'b0;
            else        req_q[k] <= (req_q[k] | set_i[k]) & mask_i[k] & ~clr_i[k];
        end
    end

    assign req_o = req_q;

    // A call outside the active range never survives a clock edge.
    assert_masked_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_q & ~$past(mask_i)) == '0);

endmodule

// File: rtl/elev_target_sel.sv
// Picks the next stop from the latched calls using the sweep rule, and flags a
// direction flip when only the opposite hall call at the current floor remains.
// Assumes: purely combinational; the caller acts on it only while the door is open.
module elev_target_sel #(
    parameter int N   = 15,
    parameter int FLW = 4
) (
    input  logic [FLW-1:0] pos_i,
    input  logic           svc_up_i,
    input  logic [N-1:0]   car_i,
    input  logic [N-1:0]   up_i,
    input  logic [N-1:0]   dn_i,
    output logic           found_o,
    output logic [FLW-1:0] tgt_o,
    output logic           dir_up_o,
    output logic           flip_o
);
    logic           ua_hit, ub_hit, da_hit, db_hit;
    logic [FLW-1:0] ua_f, ub_f, da_f, db_f;
    int             p;

    // Scan for the four candidate stops around the car.
    always_comb begin
        p = int'(pos_i);
        ua_hit = 1'b0; ua_f = '0;
        ub_hit = 1'b0; ub_f = '0;
        da_hit = 1'b0; da_f = '0;
        db_hit = 1'b0; db_f = '0;
        for (int f = N - 1; f >= 0; f--) begin
            if (f > p && (car_i[f] || up_i[f])) begin ua_hit = 1'b1; ua_f = FLW'(f); end
            if (f < p && up_i[f])               begin db_hit = 1'b1; db_f = FLW'(f); end
        end
        for (int f = 0; f < N; f++) begin
            if (f > p && dn_i[f])               begin ub_hit = 1'b1; ub_f = FLW'(f); end
            if (f < p && (car_i[f] || dn_i[f])) begin da_hit = 1'b1; da_f = FLW'(f); end
        end
    end

    // Rank candidates: current sweep first, then the reverse sweep.
    always_comb begin
        found_o  = 1'b1;
        tgt_o    = '0;
        dir_up_o = svc_up_i;
        if (svc_up_i) begin
            if      (ua_hit) begin tgt_o = ua_f; dir_up_o = 1'b1; end
            else if (ub_hit) begin tgt_o = ub_f; dir_up_o = 1'b0; end
            else if (da_hit) begin tgt_o = da_f; dir_up_o = 1'b0; end
            else if (db_hit) begin tgt_o = db_f; dir_up_o = 1'b1; end
            else             found_o = 1'b0;
        end else begin
            if      (da_hit) begin tgt_o = da_f; dir_up_o = 1'b0; end
            else if (db_hit) begin tgt_o = db_f; dir_up_o = 1'b1; end
            else if (ua_hit) begin tgt_o = ua_f; dir_up_o = 1'b1; end
            else if (ub_hit) begin tgt_o = ub_f; dir_up_o = 1'b0; end
            else             found_o = 1'b0;
        end
        flip_o = !found_o && (svc_up_i ? dn_i[pos_i] : up_i[pos_i]);
    end

endmodule

// File: rtl/elev_car_fsm.sv
// Sequencer for one elevator car: an open and a travelling condition per floor,
// a run-time floor count, sweep-ordered service and edge-triggered arrival.
// Assumes: sensors are synchronous to clk; the floor code changes only while parked.
module elev_car_fsm #(
    parameter  int MAX_FLOORS = 15,
    localparam int CFG_W      = $clog2(MAX_FLOORS + 2),
    localparam int FLW        = $clog2(MAX_FLOORS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_W-1:0]      floor_code_i,
    input  logic [MAX_FLOORS-1:0] car_btn_i,
    input  logic [MAX_FLOORS-1:0] hall_up_i,
    input  logic [MAX_FLOORS-1:0] hall_dn_i,
    input  logic [MAX_FLOORS-1:0] sensor_i,
    output logic [FLW:0]          state_o,
    output logic                  door_open_o,
    output logic                  dir_up_o
);
    import elev_pkg::*;

    localparam int N = MAX_FLOORS;

    car_mode_e      mode_q;
    logic [FLW-1:0] pos_q, tgt_q;
    logic           svc_up_q;
    logic [N-1:0]   sens_q;

    logic [N-1:0]   floor_mask, up_mask, dn_mask;
    logic [N-1:0]   car_req, up_req, dn_req;
    logic [N-1:0]   here, clr_car, clr_up, clr_dn;
    logic           sel_found, sel_dir, sel_flip, arrive;
    logic [FLW-1:0] sel_tgt;

    elev_cfg_decode #(.N(N), .CFG_W(CFG_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .code_i(floor_code_i),
        .floor_mask_o(floor_mask), .up_mask_o(up_mask), .dn_mask_o(dn_mask)
    );

    // Discard calls served by the open door at the current floor.
    always_comb begin
        here    = {{(N-1){1'b0}}, 1'b1} << pos_q;
        clr_car = (mode_q == CAR_OPEN) ? here : '0;
        clr_up  = (mode_q == CAR_OPEN &&  svc_up_q) ? here : '0;
        clr_dn  = (mode_q == CAR_OPEN && !svc_up_q) ? here : '0;
    end

    elev_req_latch #(.N(N)) i_car_calls (
        .clk(clk), .rst_n(rst_n), .set_i(car_btn_i), .mask_i(floor_mask),
        .clr_i(clr_car), .req_o(car_req)
    );
    elev_req_latch #(.N(N)) i_up_calls (
        .clk(clk), .rst_n(rst_n), .set_i(hall_up_i), .mask_i(up_mask),
        .clr_i(clr_up), .req_o(up_req)
    );
    elev_req_latch #(.N(N)) i_dn_calls (
        .clk(clk), .rst_n(rst_n), .set_i(hall_dn_i), .mask_i(dn_mask),
        .clr_i(clr_dn), .req_o(dn_req)
    );

    elev_target_sel #(.N(N), .FLW(FLW)) i_sel (
        .pos_i(pos_q), .svc_up_i(svc_up_q), .car_i(car_req), .up_i(up_req),
        .dn_i(dn_req), .found_o(sel_found), .tgt_o(sel_tgt),
        .dir_up_o(sel_dir), .flip_o(sel_flip)
    );

    // Arrival is a rising edge on the sensor of an in-range target floor.
    always_comb arrive = (mode_q == CAR_MOVING) && floor_mask[tgt_q]
                         && sensor_i[tgt_q] && !sens_q[tgt_q];

    // Main state register: depart, arrive or flip direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= CAR_OPEN;
            pos_q    <= '0;
            tgt_q    <= '0;
            svc_up_q <= 1'b1;
            sens_q   <= '0;
        end else begin
            sens_q <= sensor_i;
            case (mode_q)
                CAR_OPEN: begin
                    if (sel_found) begin
                        mode_q   <= CAR_MOVING;
                        tgt_q    <= sel_tgt;
                        svc_up_q <= sel_dir;
                    end else if (sel_flip) begin
                        svc_up_q <= ~svc_up_q;
                    end
                end
                default: begin
                    if (arrive) begin
                        mode_q <= CAR_OPEN;
                        pos_q  <= tgt_q;
                    end
                end
            endcase
        end
    end

    assign state_o     = {mode_q == CAR_MOVING, (mode_q == CAR_MOVING) ? tgt_q : pos_q};
    assign door_open_o = (mode_q == CAR_OPEN);
    assign dir_up_o    = svc_up_q;

    // Edge on the target sensor lands the car at that floor.
    assert_arrive_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CAR_MOVING && floor_mask[tgt_q] && sensor_i[tgt_q] && !sens_q[tgt_q])
        |=> (mode_q == CAR_OPEN && pos_q == $past(tgt_q)));

    // A low target sensor keeps the car travelling.
    assert_no_arrival_without_sensor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CAR_MOVING && !sensor_i[tgt_q]) |=> mode_q == CAR_MOVING);

    // The service direction is frozen during travel.
    assert_dir_stable_moving_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == CAR_MOVING |=> $stable(svc_up_q));

    // A departure never targets the floor the car stands at.
    assert_depart_elsewhere_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q == CAR_MOVING) |-> tgt_q != $past(pos_q));

endmodule

// File: tb/test_elev_car_fsm.sv
module test_elev_car_fsm;
    localparam int N  = 15;
    localparam int FW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   code = '0;
    logic [N-1:0] car = '0, hu = '0, hd = '0, sens = '0;
    logic [FW:0]  state;
    logic         door, dir_up;

    elev_car_fsm #(.MAX_FLOORS(N)) i_elev_car_fsm (
        .clk(clk), .rst_n(rst_n), .floor_code_i(code), .car_btn_i(car),
        .hall_up_i(hu), .hall_dn_i(hd), .sensor_i(sens),
        .state_o(state), .door_open_o(door), .dir_up_o(dir_up)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    bit    armed = 0;
    string tag = "R1";

    // ---------------- behavioural reference ----------------
    int m_mov, m_pos, m_tgt, m_up, m_cfg;
    int m_car[N], m_uq[N], m_dq[N], m_sq[N];
    int s_hit, s_t, s_d, s_flip, n_act, arr;

    function automatic int floors_of(int v);
        if (v < 3) return 2;
        if (v - 1 > N) return N;
        return v - 1;
    endfunction

    // Walk outward from the car in the preferred order of the sweep rules.
    task automatic choose(output int hit, output int t, output int d, output int fl);
        int ord[4];
        hit = 0; t = 0; d = m_up; fl = 0;
        if (m_up != 0) begin ord[0] = 0; ord[1] = 1; ord[2] = 2; ord[3] = 3; end
        else           begin ord[0] = 2; ord[1] = 3; ord[2] = 0; ord[3] = 1; end
        for (int i = 0; i < 4 && hit == 0; i++) begin
            case (ord[i])
                0: for (int f = m_pos + 1; f < N && hit == 0; f++)
                       if (m_car[f] != 0 || m_uq[f] != 0) begin hit = 1; t = f; d = 1; end
                1: for (int f = N - 1; f > m_pos && hit == 0; f--)
                       if (m_dq[f] != 0) begin hit = 1; t = f; d = 0; end
                2: for (int f = m_pos - 1; f >= 0 && hit == 0; f--)
                       if (m_car[f] != 0 || m_dq[f] != 0) begin hit = 1; t = f; d = 0; end
                default: for (int f = 0; f < m_pos && hit == 0; f++)
                       if (m_uq[f] != 0) begin hit = 1; t = f; d = 1; end
            endcase
        end
        if (hit == 0) fl = (m_up != 0) ? m_dq[m_pos] : m_uq[m_pos];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mov = 0; m_pos = 0; m_tgt = 0; m_up = 1; m_cfg = 0;
            for (int f = 0; f < N; f++) begin m_car[f] = 0; m_uq[f] = 0; m_dq[f] = 0; m_sq[f] = 0; end
        end else begin
            n_act = floors_of(m_cfg);
            choose(s_hit, s_t, s_d, s_flip);
            arr = (m_mov != 0 && m_tgt < n_act && sens[m_tgt] && m_sq[m_tgt] == 0) ? 1 : 0;
            for (int f = 0; f < N; f++) begin
                m_car[f] = (m_car[f] != 0 || car[f]) && f < n_act;
                m_uq[f]  = (m_uq[f] != 0 || hu[f]) && f < n_act - 1;
                m_dq[f]  = (m_dq[f] != 0 || hd[f]) && f >= 1 && f < n_act;
            end
            if (m_mov == 0) begin
                m_car[m_pos] = 0;
                if (m_up != 0) m_uq[m_pos] = 0; else m_dq[m_pos] = 0;
                if (s_hit != 0) begin m_mov = 1; m_tgt = s_t; m_up = s_d; end
                else if (s_flip != 0) m_up = 1 - m_up;
            end else if (arr != 0) begin
                m_mov = 0; m_pos = m_tgt;
            end
            for (int f = 0; f < N; f++) m_sq[f] = sens[f];
            m_cfg = int'(code);
        end
    end

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && armed) begin
            int es;
            es = m_mov * 16 + (m_mov != 0 ? m_tgt : m_pos);
            n_cmp++;
            if (int'(state) != es || int'(door) != 1 - m_mov || int'(dir_up) != m_up) begin
                n_bad++;
                $display("FAIL %s cycle %0d: state=%0d door=%0d dir=%0d expected state=%0d door=%0d dir=%0d",
                         tag, cyc, state, door, dir_up, es, 1 - m_mov, m_up);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic [N-1:0] c, input logic [N-1:0] u, input logic [N-1:0] d);
        @(negedge clk); #2; car = c; hu = u; hd = d;
        @(negedge clk); #2; car = '0; hu = '0; hd = '0;
    endtask

    task automatic pulse_sensor(input int f);
        @(negedge clk); #2; sens[f] = 1'b1;
        @(negedge clk); #2; sens[f] = 1'b0;
    endtask

    function automatic logic [N-1:0] bit_at(input int f);
        return N'(1) << f;
    endfunction

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        idle(3); #2; rst_n = 1'b1;
        idle(1); armed = 1;
        tag = "R1";
        chk("R1 state", int'(state), 0);
        chk("R1 door", int'(door), 1);
        chk("R1 dir", int'(dir_up), 1);

        tag = "R2/R5";
        code = 5'b01010;                         // nine floors
        press(bit_at(6), '0, '0); idle(2);
        chk("R5 travelling to 6", int'(state), 16 + 6);
        chk("R5 door closed", int'(door), 0);
        tag = "R7";
        pulse_sensor(7); idle(1);
        chk("R7 stray sensor", int'(state), 16 + 6);
        tag = "R6";
        pulse_sensor(6);
        chk("R6 arrive at 6", int'(state), 6);
        tag = "R3";
        press(bit_at(9), '0, '0); idle(3);
        chk("R3 floor 9 out of range", int'(state), 6);
        tag = "R2";
        press(bit_at(8), '0, '0); idle(2);
        chk("R2 ninth floor valid", int'(state), 16 + 8);
        pulse_sensor(8);
        chk("R6 arrive at 8", int'(state), 8);

        tag = "R7";
        @(negedge clk); #2; sens[2] = 1'b1;      // held high before departure
        press(bit_at(2), '0, '0); idle(6);
        chk("R7 held sensor", int'(state), 16 + 2);
        @(negedge clk); #2; sens[2] = 1'b0;
        pulse_sensor(2);
        chk("R6 arrive at 2 after fresh edge", int'(state), 2);
        press(bit_at(0), '0, '0); idle(2); pulse_sensor(0); idle(2);

        tag = "R8/R4";
        press(bit_at(6), bit_at(3), bit_at(5)); idle(2);
        chk("R8 up-call 3 first", int'(state), 16 + 3);
        chk("R8 dir up", int'(dir_up), 1);
        pulse_sensor(3); idle(2);
        chk("R8 car call 6 before down-call 5", int'(state), 16 + 6);
        pulse_sensor(6); idle(2);
        tag = "R9";
        chk("R9 down-call 5 last", int'(state), 16 + 5);
        chk("R9 dir down", int'(dir_up), 0);
        pulse_sensor(5);

        tag = "R10";
        press('0, bit_at(5), '0); idle(3);
        chk("R10 flip to up", int'(dir_up), 1);
        chk("R10 stays open at 5", int'(state), 5);

        tag = "R9";
        press(bit_at(1), bit_at(2), bit_at(3)); idle(2);
        chk("R9 reverse to down-call 3", int'(state), 16 + 3);
        pulse_sensor(3); idle(2);
        chk("R9 car 1 before up-call 2", int'(state), 16 + 1);
        pulse_sensor(1); idle(2);
        chk("R9 up-call 2 last", int'(state), 16 + 2);
        chk("R9 dir up", int'(dir_up), 1);
        pulse_sensor(2); idle(2);

        tag = "R3";
        code = 5'd5;                             // four floors
        idle(2);
        press(bit_at(7), bit_at(3), bit_at(0)); idle(4);
        chk("R3 out-of-range calls ignored", int'(state), 2);
        chk("R3 door stays open", int'(door), 1);

        tag = "R1";
        code = 5'b01010;
        press(bit_at(4), '0, '0); idle(1);
        press(bit_at(8), '0, '0);
        @(negedge clk); #2; rst_n = 1'b0;
        idle(3); #2; rst_n = 1'b1;
        idle(1); pulse_sensor(8); idle(4);
        chk("R1 calls cleared by reset", int'(state), 0);
        chk("R1 dir after reset", int'(dir_up), 1);

        tag = "R4/R8/R9/R10/R11";
        for (int ph = 0; ph < 2; ph++) begin
            if (ph == 1) begin
                while (m_mov != 0) begin
                    @(negedge clk); #2; sens = bit_at(m_tgt);
                    @(negedge clk); #2; sens = '0;
                end
                code = 5'd31;                    // clamps to fifteen floors
                tag = "R2 clamp";
            end
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk); #2;
                car  = ($urandom % 8 == 0) ? bit_at($urandom % N) : '0;
                hu   = ($urandom % 10 == 0) ? bit_at($urandom % N) : '0;
                hd   = ($urandom % 10 == 0) ? bit_at($urandom % N) : '0;
                sens = (m_mov != 0 && $urandom % 3 == 0) ? bit_at(m_tgt) : '0;
                if ($urandom % 11 == 0) sens = sens | bit_at($urandom % N);
            end
        end
        @(negedge clk); #2; car = '0; hu = '0; hd = '0; sens = '0;
        idle(2);
        finish_run();
    end
endmodule